// File: doc/BRIEF.md
# Block-Write Configuration Slave

This block is a two-wire serial slave that loads a small bank of 8-bit configuration registers. The registers set the clock-output enables and the spread-spectrum switch of a clock generator. It accepts one kind of transaction only, a block write. The transaction is framed by a START and a STOP and carries these bytes in order: a device address, a command byte, a byte count, and then the data bytes. The data always lands in the bank from register 0 upward. There is no register index, no read path and no clock stretching.

The serial clock and data lines are oversampled by a system clock that is much faster than the serial clock. Both lines pass through a short synchronizer. Edges and bus conditions are recovered from the synchronized samples. The slave answers each accepted byte by pulling the data line low for one bit time. Decoded register fields leave the block as plain enable levels.

Top module: `blkw_slave`

## Requirements
- R1: After reset, `spreadOn` is 0, `fastMemMode` is 0, and every bit of `fixedEn`, `memClkEn` and `busClkEn` is 1.
- R2: The slave acknowledges an address byte of D2h, which is the 7-bit address 1101001 followed by write bit 0. Any other address byte, including D3h (a read), is not acknowledged. After such a byte, the rest of the transaction gets no acknowledge and changes no register until the next START.
- R3: The slave acknowledges the byte after the address (the command byte) whatever its value. The command byte changes no register.
- R4: The slave acknowledges a byte count of 1 to 32. A count of 0 or above 32 is not acknowledged, and the rest of the transaction is ignored until the next START.
- R5: Each byte is received MSB first. Data byte k (counting from 0) is written to register k. The register fields map to outputs as follows:
  - register 0 bit 3 drives `spreadOn`, and register 0 bits 2..0 drive `fixedEn[2:0]`;
  - register 1 drives `memClkEn[7:0]`;
  - register 2 bits 7..1 drive `busClkEn[6:0]`, and register 2 bit 0 is reserved;
  - register 3 bit 0 drives `fastMemMode`.
- R6: A STOP may follow any complete byte, and the bytes already written stay in the bank. A byte cut short by a STOP writes nothing.
- R7: Data bytes past the byte count, or past the eighth register, are acknowledged and discarded. Writes never wrap back to register 0.
- R8: `sdaPullLow` goes high only while SCL is low, after the SCL falling edge that ends the eighth bit of an accepted byte. It goes low again at the next SCL falling edge. The configuration outputs change only at the start of such an acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling system clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Serial clock line level |
| sdaIn | input | 1 | Serial data line level |
| sdaPullLow | output | 1 | 1 pulls the data line low (open-drain acknowledge) |
| spreadOn | output | 1 | Spread-spectrum enable |
| fixedEn | output | 3 | Enables for the three fixed clock outputs |
| memClkEn | output | 8 | Memory clock enables |
| busClkEn | output | 7 | Peripheral and graphics bus clock enables |
| fastMemMode | output | 1 | Higher-rate memory clock mode |

## Verification
The hardest situations to reach are the ones where nothing is supposed to happen. One is a transaction that goes on after a rejected address or count. The other is a STOP that lands inside a byte. The stimulus keeps clocking full cycles after both kinds of rejection. It also cuts a byte after four bits and follows it with a STOP. It then reads the enable outputs to show that no register moved. A sweep over all 256 address bytes covers the address match. A 32-byte transfer shows that writes stop at the end of the bank and do not wrap.

// File: rtl/blkw_pkg.sv
`timescale 1ns/1ps
package blkw_pkg;
  localparam int unsigned BANK_DEPTH = 8;
  localparam int unsigned IDX_W = $clog2(BANK_DEPTH);
  localparam int unsigned MAX_COUNT = 32;
  localparam int unsigned CNT_W = $clog2(MAX_COUNT + 1);
  localparam logic [7:0] DEV_ADDR_BYTE = 8'hD2;

  typedef enum logic [2:0] {
    PH_IDLE, PH_ADDR, PH_CMD, PH_COUNT, PH_DATA, PH_IGNORE
  } phase_t;

  typedef struct packed {
    logic             wrEn;
    logic [IDX_W-1:0] wrIdx;
    logic [7:0]       wrData;
  } bankWrite_t;

  function automatic logic [7:0] bankResetValue(input int idx);
    case (idx)
      0: return 8'h07;
      1: return 8'hFF;
      2: return 8'hFE;
      default: return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/blkw_linesync.sv
`timescale 1ns/1ps
module blkw_linesync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sclRise,
  output logic sclFall,
  output logic startSeen,
  output logic stopSeen,
  output logic sdaBit
);
  logic [STAGES-1:0] sclQ, sdaQ;
  logic sclPrev, sdaPrev;
  logic sclNow, sdaNow;

  assign sclNow = sclQ[STAGES-1];
  assign sdaNow = sdaQ[STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclQ    <= '1;
      sdaQ    <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclQ    <= {sclQ[STAGES-2:0], sclIn};
      sdaQ    <= {sdaQ[STAGES-2:0], sdaIn};
      sclPrev <= sclNow;
      sdaPrev <= sdaNow;
    end
  end

  assign sclRise   = sclNow & ~sclPrev;
  assign sclFall   = ~sclNow & sclPrev;
  assign startSeen = sclNow & sclPrev & sdaPrev & ~sdaNow;
  assign stopSeen  = sclNow & sclPrev & ~sdaPrev & sdaNow;
  assign sdaBit    = sdaNow;
endmodule

// File: rtl/blkw_ctrl.sv
`timescale 1ns/1ps
module blkw_ctrl
  import blkw_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclRise,
  input  logic       sclFall,
  input  logic       startSeen,
  input  logic       stopSeen,
  input  logic       sdaBit,
  output bankWrite_t wrStrobe,
  output logic       ackDrive
);
  phase_t           phase;
  logic [7:0]       shiftReg;
  logic [3:0]       bitCnt;
  logic             inAck;
  logic [CNT_W-1:0] remaining;
  logic [CNT_W-1:0] wrPtr;
  logic             countOk;

  assign countOk = (shiftReg != 8'd0) && (shiftReg <= 8'(MAX_COUNT));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase     <= PH_IDLE;
      shiftReg  <= '0;
      bitCnt    <= '0;
      inAck     <= 1'b0;
      remaining <= '0;
      wrPtr     <= '0;
      ackDrive  <= 1'b0;
      wrStrobe  <= '0;
    end else begin
      wrStrobe.wrEn <= 1'b0;
      if (startSeen) begin
        phase    <= PH_ADDR;
        bitCnt   <= '0;
        inAck    <= 1'b0;
        ackDrive <= 1'b0;
      end else if (stopSeen) begin
        phase    <= PH_IDLE;
        bitCnt   <= '0;
        inAck    <= 1'b0;
        ackDrive <= 1'b0;
      end else if (phase != PH_IDLE && phase != PH_IGNORE) begin
        if (sclRise && !inAck && bitCnt < 4'd8) begin
          shiftReg <= {shiftReg[6:0], sdaBit};
          bitCnt   <= bitCnt + 4'd1;
        end
        if (sclFall) begin
          if (inAck) begin
            ackDrive <= 1'b0;
            inAck    <= 1'b0;
            bitCnt   <= '0;
          end else if (bitCnt == 4'd8) begin
            case (phase)
              PH_ADDR: begin
                if (shiftReg == DEV_ADDR_BYTE) begin
                  phase <= PH_CMD; ackDrive <= 1'b1; inAck <= 1'b1;
                end else begin
                  phase <= PH_IGNORE;
                end
              end
              PH_CMD: begin
                phase <= PH_COUNT; ackDrive <= 1'b1; inAck <= 1'b1;
              end
              PH_COUNT: begin
                if (countOk) begin
                  phase     <= PH_DATA;
                  remaining <= shiftReg[CNT_W-1:0];
                  wrPtr     <= '0;
                  ackDrive  <= 1'b1;
                  inAck     <= 1'b1;
                end else begin
                  phase <= PH_IGNORE;
                end
              end
              PH_DATA: begin
                ackDrive <= 1'b1;
                inAck    <= 1'b1;
                if (remaining != '0) begin
                  remaining <= remaining - 1'b1;
                  wrPtr     <= wrPtr + 1'b1;
                  if (wrPtr < CNT_W'(BANK_DEPTH)) begin
                    wrStrobe.wrEn   <= 1'b1;
                    wrStrobe.wrIdx  <= wrPtr[IDX_W-1:0];
                    wrStrobe.wrData <= shiftReg;
                  end
                end
              end
              default: phase <= PH_IDLE;
            endcase
          end
        end
      end
    end
  end
endmodule

// File: rtl/blkw_regs.sv
`timescale 1ns/1ps
module blkw_regs
  import blkw_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  bankWrite_t wrStrobe,
  output logic       spreadOn,
  output logic [2:0] fixedEn,
  output logic [7:0] memClkEn,
  output logic [6:0] busClkEn,
  output logic       fastMemMode
);
  logic [7:0] bank [BANK_DEPTH];
  logic       unusedBankBits;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < int'(BANK_DEPTH); i++) bank[i] <= bankResetValue(i);
    end else if (wrStrobe.wrEn) begin
      bank[wrStrobe.wrIdx] <= wrStrobe.wrData;
    end
  end

  assign spreadOn    = bank[0][3];
  assign fixedEn     = bank[0][2:0];
  assign memClkEn    = bank[1];
  assign busClkEn    = bank[2][7:1];
  assign fastMemMode = bank[3][0];

  always_comb begin
    unusedBankBits = ^{bank[0][7:4], bank[2][0], bank[3][7:1]};
    for (int i = 4; i < int'(BANK_DEPTH); i++) unusedBankBits = unusedBankBits ^ (^bank[i]);
  end
endmodule

// File: rtl/blkw_slave.sv
`timescale 1ns/1ps
module blkw_slave
  import blkw_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  output logic       sdaPullLow,
  output logic       spreadOn,
  output logic [2:0] fixedEn,
  output logic [7:0] memClkEn,
  output logic [6:0] busClkEn,
  output logic       fastMemMode
);
  logic sclRise, sclFall, startSeen, stopSeen, sdaBit;
  bankWrite_t wrStrobe;

  blkw_linesync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .sclRise(sclRise), .sclFall(sclFall), .startSeen(startSeen),
    .stopSeen(stopSeen), .sdaBit(sdaBit)
  );

  blkw_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .sclRise(sclRise), .sclFall(sclFall),
    .startSeen(startSeen), .stopSeen(stopSeen), .sdaBit(sdaBit),
    .wrStrobe(wrStrobe), .ackDrive(sdaPullLow)
  );

  blkw_regs u_regs (
    .clk(clk), .rstN(rstN), .wrStrobe(wrStrobe),
    .spreadOn(spreadOn), .fixedEn(fixedEn), .memClkEn(memClkEn),
    .busClkEn(busClkEn), .fastMemMode(fastMemMode)
  );
endmodule

// File: rtl/blkw_checker.sv
`timescale 1ns/1ps
module blkw_checker (
  input logic       clk,
  input logic       rstN,
  input logic       sclIn,
  input logic       sdaPullLow,
  input logic       spreadOn,
  input logic [2:0] fixedEn,
  input logic [7:0] memClkEn,
  input logic [6:0] busClkEn,
  input logic       fastMemMode
);
  logic [19:0] cfgVec;
  assign cfgVec = {spreadOn, fixedEn, memClkEn, busClkEn, fastMemMode};

  always @(negedge clk) begin
    if (!rstN) begin
      a_r1_reset_values: assert (cfgVec == {1'b0, 3'b111, 8'hFF, 7'h7F, 1'b0})
        else $error("reset values wrong");
    end
  end

  a_r8_ack_starts_scl_low: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaPullLow) |-> !sclIn);

  a_r8_ack_ends_scl_low: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sdaPullLow) |-> !sclIn);

  a_r5_update_with_ack: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(cfgVec) |-> $past(sdaPullLow));
endmodule

bind blkw_slave blkw_checker u_chk (
  .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaPullLow(sdaPullLow),
  .spreadOn(spreadOn), .fixedEn(fixedEn), .memClkEn(memClkEn),
  .busClkEn(busClkEn), .fastMemMode(fastMemMode)
);

// File: tb/tb_blkw_slave.sv
`timescale 1ns/1ps
module tb_blkw_slave;
  localparam int Q = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclDrv = 1'b1;
  logic sdaDrv = 1'b1;
  logic sdaIn;
  logic sdaPullLow, spreadOn, fastMemMode;
  logic [2:0] fixedEn;
  logic [7:0] memClkEn;
  logic [6:0] busClkEn;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  logic [7:0] expReg [4];

  always #2.5 clk = ~clk;
  assign sdaIn = sdaDrv & ~sdaPullLow;

  blkw_slave dut (
    .clk(clk), .rstN(rstN), .sclIn(sclDrv), .sdaIn(sdaIn),
    .sdaPullLow(sdaPullLow), .spreadOn(spreadOn), .fixedEn(fixedEn),
    .memClkEn(memClkEn), .busClkEn(busClkEn), .fastMemMode(fastMemMode)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  task automatic waitQ(input int n);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic busStart();
    sdaDrv = 1'b1; waitQ(1);
    sclDrv = 1'b1; waitQ(1);
    sdaDrv = 1'b0; waitQ(1);
    sclDrv = 1'b0; waitQ(2);
  endtask

  task automatic busStop();
    sdaDrv = 1'b0; waitQ(1);
    sclDrv = 1'b1; waitQ(1);
    sdaDrv = 1'b1; waitQ(2);
  endtask

  task automatic sendBit(input logic b);
    sdaDrv = b; waitQ(1);
    sclDrv = 1'b1; waitQ(2);
    sclDrv = 1'b0; waitQ(2);
  endtask

  task automatic sendByte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) sendBit(b[i]);
    sdaDrv = 1'b1; waitQ(1);
    sclDrv = 1'b1; waitQ(1);
    acked = ~sdaIn;
    waitQ(1);
    sclDrv = 1'b0; waitQ(2);
  endtask

  function automatic logic [7:0] pat(input int s, input int i);
    return 8'((s * 37 + i * 91 + 13) & 255);
  endfunction

  task automatic checkOutputs(input string req);
    check(spreadOn == expReg[0][3], req, "spreadOn", 32'(spreadOn), 32'(expReg[0][3]));
    check(fixedEn == expReg[0][2:0], req, "fixedEn", 32'(fixedEn), 32'(expReg[0][2:0]));
    check(memClkEn == expReg[1], req, "memClkEn", 32'(memClkEn), 32'(expReg[1]));
    check(busClkEn == expReg[2][7:1], req, "busClkEn", 32'(busClkEn), 32'(expReg[2][7:1]));
    check(fastMemMode == expReg[3][0], req, "fastMemMode", 32'(fastMemMode), 32'(expReg[3][0]));
  endtask

  // full transaction; partialTail cuts a further byte after four bits (R6)
  task automatic doBlock(input logic [7:0] addr, input logic [7:0] cmd, input logic [7:0] cnt,
                         input int nData, input int seed, input bit partialTail, input string req);
    bit a;
    bit live;
    logic [7:0] d;
    busStart();
    live = (addr == 8'hD2);
    sendByte(addr, a);
    check(a == live, "R2", "address ack", 32'(a), 32'(live));
    sendByte(cmd, a);
    check(a == live, "R3", "command ack", 32'(a), 32'(live));
    sendByte(cnt, a);
    live = live && (cnt != 8'd0) && (cnt <= 8'd32);
    check(a == live, "R4", "count ack", 32'(a), 32'(live));
    for (int i = 0; i < nData; i++) begin
      d = pat(seed, i);
      sendByte(d, a);
      check(a == live, (i >= int'(cnt) || i >= 8) ? "R7" : "R5", "data ack", 32'(a), 32'(live));
      if (live && i < int'(cnt) && i < 4) expReg[i] = d;
    end
    if (partialTail) begin
      d = pat(seed, nData);
      for (int i = 7; i >= 4; i--) sendBit(d[i]);
    end
    busStop();
    checkOutputs(req);
  endtask

  initial begin
    bit a;
    expReg[0] = 8'h07; expReg[1] = 8'hFF; expReg[2] = 8'hFE; expReg[3] = 8'h00;
    repeat (10) @(negedge clk);
    checkOutputs("R1");
    check(sdaPullLow == 1'b0, "R8", "idle pull", 32'(sdaPullLow), 32'd0);
    rstN = 1'b1;
    repeat (10) @(negedge clk);
    checkOutputs("R1");

    // R5: counts 1..8, each with exactly that many data bytes
    for (int c = 1; c <= 8; c++) doBlock(8'hD2, 8'h00, 8'(c), c, c, 1'b0, "R5");
    // R3: nonzero command byte changes nothing on its own
    doBlock(8'hD2, 8'hA5, 8'd2, 2, 20, 1'b0, "R3");
    // R7: more bytes than the count
    doBlock(8'hD2, 8'h00, 8'd3, 6, 21, 1'b0, "R7");
    // R7: full 32-byte transfer, no wrap past the bank
    doBlock(8'hD2, 8'h00, 8'd32, 32, 22, 1'b0, "R7");
    // R4: illegal counts
    doBlock(8'hD2, 8'h00, 8'd0, 3, 23, 1'b0, "R4");
    doBlock(8'hD2, 8'h00, 8'd33, 3, 24, 1'b0, "R4");
    doBlock(8'hD2, 8'h00, 8'd255, 2, 25, 1'b0, "R4");
    // R6: early STOP after whole bytes, then STOP inside a byte
    doBlock(8'hD2, 8'h00, 8'd5, 2, 26, 1'b0, "R6");
    doBlock(8'hD2, 8'h00, 8'd4, 1, 27, 1'b1, "R6");
    doBlock(8'hD2, 8'h00, 8'd4, 0, 28, 1'b1, "R6");
    // R2: wrong address, read bit, followed by a full body
    doBlock(8'hD3, 8'h00, 8'd4, 4, 29, 1'b0, "R2");
    doBlock(8'h52, 8'h00, 8'd4, 4, 30, 1'b0, "R2");
    doBlock(8'hD0, 8'h00, 8'd4, 4, 31, 1'b0, "R2");
    // R2: sweep of every address byte
    for (int ab = 0; ab < 256; ab++) begin
      busStart();
      sendByte(8'(ab), a);
      check(a == (ab == 8'hD2), "R2", "address sweep ack", 32'(a), 32'(ab == 8'hD2));
      busStop();
    end
    checkOutputs("R2");
    // R8: the line is released after the sweep
    check(sdaPullLow == 1'b0, "R8", "released", 32'(sdaPullLow), 32'd0);
    // final legal write after all rejections
    doBlock(8'hD2, 8'h00, 8'd4, 4, 40, 1'b0, "R5");

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int n = 0; n < 190000; n++) begin
      @(posedge clk);
      if (finished) break;
    end
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule